// File: doc/BRIEF.md
# Multi-Source Interrupt Flag Controller

This block gathers six single-cycle event pulses (periodic tick, time alarm, update-ended, wake-up, kickstart and memory-clear) into sticky flags. Each flag is gated with its own enable bit. The gated results are ORed into a summary bit. The summary drives an output-enable line that pulls an external active-low, open-drain request wire. Flags are set whenever their event fires, whatever the enable bits say, so software can poll them without taking interrupts.

The three timekeeping flags live in a primary status register. Reading that register clears them, but only once the read has ended. The register value is captured when the read starts and held for as long as the read lasts. Events that arrive during the read are parked and posted afterwards. The three system flags live in an extended status register, which reads leave untouched. Software clears these flags by writing ones to them. A control register holds the primary enables and a hold bit. Writing the hold bit as 1 drops the update-ended enable.

Registers are reached through a level read strobe and a one-cycle write strobe. Both share a 2-bit address: 0 is primary status, 1 is control, 2 is extended status and 3 is extended enable. The address must stay constant while the read strobe is high.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags, enables and the hold bit are 0, `irq_drive` is 0, and every register reads 0x00.
- R2: A pulse on any event input sets its flag on the next clock edge, whatever its enable. A disabled flag does not raise `irq_drive`. Event bits are 0 periodic, 1 alarm, 2 update-ended, 3 wake-up, 4 kickstart and 5 memory-clear.
- R3: `irq_drive` is 1 exactly when the summary bit is 1. The summary bit is the OR, over all six sources, of flag AND enable. It appears in bit 7 of primary status.
- R4: If a flag is already set, writing its enable to 1 raises `irq_drive` in the cycle after the write.
- R5: Primary status (address 0) reads as {summary, periodic, alarm, update, 4'b0}. When the read strobe falls, those three flags clear.
- R6: `rdata` is captured in the first cycle of a read and stays constant while the strobe is high. A primary event that arrives during a read, or in the cycle the read ends, is set after the read ends.
- R7: Extended status (address 2) holds wake-up, kickstart and memory-clear in bits 0, 1 and 2. Reads do not change these flags. Writing 1 to a bit clears that flag, unless its event fires in the same cycle, in which case the flag stays set.
- R8: Bits 3..0 of primary status always read 0. Writes to address 0 change nothing.
- R9: Control (address 1) holds the hold bit in bit 7 and the periodic, alarm and update-ended enables in bits 6, 5 and 4. A write with bit 7 set stores 0 in the update-ended enable, whatever bit 4 carries. Extended enable (address 3) uses bits 0..2, in the same order as extended status.
- R10: Once `irq_drive` is 1, it stays 1 until every enabled flag is cleared or disabled. Clearing only some of them leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 6 | Event pulses, one bit per source |
| rd_en | input | 1 | Read strobe, high for the whole read |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, captured at read start |
| irq_drive | output | 1 | Enable for the low-drive of the open-drain request wire |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the end of a primary status read (which clears the flags) and a new primary event. The bench drops the read strobe in the same cycle as an update-ended pulse, while an alarm pulse is already parked from the middle of the read. It then checks that both flags appear in the next read. The second pair is a write-one clear of a system flag and that flag's own event. The bench drives both in one cycle and checks that the flag reads back set.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   typedef enum logic [1:0] {
      A_STAT  = 2'd0,
      A_CTRL  = 2'd1,
      A_XSTAT = 2'd2,
      A_XEN   = 2'd3
   } reg_addr_e;

   // index of the update-ended source among the primary sources
   localparam int UPD_IDX = 2;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter bit CLR_ON_READ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic hold,
   input  logic clr,
   output logic flag
);
   generate
      if (CLR_ON_READ) begin : g_cor
         logic parked_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag     <= 1'b0;
               parked_q <= 1'b0;
            end else if (hold) begin
               parked_q <= parked_q | evt;
            end else if (clr) begin
               flag     <= parked_q | evt;
               parked_q <= 1'b0;
            end else begin
               flag <= flag | evt;
            end
         end
      end else begin : g_w1c
         logic unused_hold;
         assign unused_hold = hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag <= 1'b0;
            else        flag <= evt | (flag & ~clr);
         end
      end
   endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import irq_flag_pkg::*;
#(
   parameter int NUM_PRI = 3,
   parameter int NUM_EXT = 3,
   parameter int DATA_W  = 8,
   localparam int NUM_SRC = NUM_PRI + NUM_EXT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic               wr_en,
   input  reg_addr_e          addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SRC-1:0] flags,
   input  logic               summary,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_SRC-1:0] en,
   output logic               freeze,
   output logic               rd_clr,
   output logic [NUM_EXT-1:0] w1c,
   output logic               rd_q
);
   localparam int TOP = DATA_W - 1;

   logic              hold_q;
   reg_addr_e         rd_addr_q;
   logic [DATA_W-1:0] rd_word;
   logic              rd_first;
   logic              unused_wbits;

   assign unused_wbits = ^wdata;
   assign rd_first = rd_en & ~rd_q;
   assign freeze   = rd_en & (addr == A_STAT);
   assign rd_clr   = rd_q & ~rd_en & (rd_addr_q == A_STAT);
   assign w1c      = (wr_en && addr == A_XSTAT) ? wdata[NUM_EXT-1:0] : '0;

   always_comb begin
      rd_word = '0;
      case (addr)
         A_STAT: begin
            rd_word[TOP] = summary;
            for (int i = 0; i < NUM_PRI; i++) rd_word[TOP-1-i] = flags[i];
         end
         A_CTRL: begin
            rd_word[TOP] = hold_q;
            for (int i = 0; i < NUM_PRI; i++) rd_word[TOP-1-i] = en[i];
         end
         A_XSTAT: for (int j = 0; j < NUM_EXT; j++) rd_word[j] = flags[NUM_PRI+j];
         default: for (int j = 0; j < NUM_EXT; j++) rd_word[j] = en[NUM_PRI+j];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q      <= 1'b0;
         rd_addr_q <= A_STAT;
         rdata     <= '0;
      end else begin
         rd_q <= rd_en;
         if (rd_first) begin
            rd_addr_q <= addr;
            rdata     <= rd_word;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= '0;
         hold_q <= 1'b0;
      end else if (wr_en) begin
         if (addr == A_CTRL) begin
            hold_q <= wdata[TOP];
            for (int i = 0; i < NUM_PRI; i++) en[i] <= wdata[TOP-1-i];
            if (wdata[TOP]) en[UPD_IDX] <= 1'b0;
         end else if (addr == A_XEN) begin
            en[NUM_SRC-1:NUM_PRI] <= wdata[NUM_EXT-1:0];
         end
      end
   end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_flag_pkg::*;
#(
   parameter int NUM_PRI = 3,
   parameter int NUM_EXT = 3,
   parameter int DATA_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_PRI+NUM_EXT-1:0] evt_i,
   input  logic                       rd_en,
   input  logic                       wr_en,
   input  logic [1:0]                 addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic                       irq_drive
);
   localparam int NUM_SRC = NUM_PRI + NUM_EXT;

   generate
      if (NUM_PRI > DATA_W - 5) begin : g_bad_pri
         $error("primary flags overlap the zero field");
      end
      if (NUM_EXT > DATA_W) begin : g_bad_ext
         $error("extended flags exceed data width");
      end
      if (NUM_PRI <= UPD_IDX) begin : g_bad_upd
         $error("update-ended source missing");
      end
   endgenerate

   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] en;
   logic [NUM_EXT-1:0] w1c;
   logic               freeze;
   logic               rd_clr;
   logic               rd_q;
   logic               summary;

   assign summary   = |(flag_q & en);
   assign irq_drive = summary;

   irq_regs #(.NUM_PRI(NUM_PRI), .NUM_EXT(NUM_EXT), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .addr    (reg_addr_e'(addr)),
      .wdata   (wdata),
      .flags   (flag_q),
      .summary (summary),
      .rdata   (rdata),
      .en      (en),
      .freeze  (freeze),
      .rd_clr  (rd_clr),
      .w1c     (w1c),
      .rd_q    (rd_q)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i < NUM_PRI) begin : g_pri
         irq_flag_cell #(.CLR_ON_READ(1'b1)) u_cell (
            .clk (clk), .rst_n (rst_n), .evt (evt_i[i]),
            .hold (freeze), .clr (rd_clr), .flag (flag_q[i])
         );
      end else begin : g_ext
         irq_flag_cell #(.CLR_ON_READ(1'b0)) u_cell (
            .clk (clk), .rst_n (rst_n), .evt (evt_i[i]),
            .hold (1'b0), .clr (w1c[i-NUM_PRI]), .flag (flag_q[i])
         );
      end
   end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
   parameter int NUM_PRI = 3,
   parameter int NUM_SRC = 6,
   parameter int DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               rd_en,
   input logic               wr_en,
   input logic [1:0]         addr,
   input logic [DATA_W-1:0]  wdata,
   input logic [DATA_W-1:0]  rdata,
   input logic               irq_drive,
   input logic [NUM_SRC-1:0] flags,
   input logic [NUM_SRC-1:0] en,
   input logic               rd_q
);
   assert_evt_sets_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[NUM_PRI] |=> flags[NUM_PRI]);

   assert_preset_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[0] && flags[NUM_PRI]) |=> irq_drive);

   assert_rdata_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_q) |=> $stable(rdata));

   assert_ext_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[NUM_PRI] && !(wr_en && addr == 2'd2 && wdata[0])) |=> flags[NUM_PRI]);

   assert_hold_drops_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1 && wdata[DATA_W-1]) |=> !en[2]);

   assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_drive && !wr_en && !(rd_q && !rd_en)) |=> irq_drive);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
   .NUM_PRI(NUM_PRI), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .rd_en     (rd_en),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .irq_drive (irq_drive),
   .flags     (flag_q),
   .en        (en),
   .rd_q      (rd_q)
);

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
   localparam int CLK_NS = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] evt_i = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit         is_irq;
      logic [7:0] exp;
      string      req;
   } item_t;
   item_t sb_q[$];

   always #(CLK_NS/2) clk = ~clk;

   irq_flag_ctrl u_irq_flag_ctrl (
      .clk (clk), .rst_n (rst_n), .evt_i (evt_i), .rd_en (rd_en),
      .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata),
      .irq_drive (irq_drive)
   );

   // monitor: pops expected items and compares away from the active edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = sb_q.pop_front();
         act = it.is_irq ? {7'd0, irq_drive} : rdata;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: %s actual=%02h expected=%02h",
                     it.req, it.is_irq ? "irq" : "rdata", act, it.exp);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_item(input bit is_irq, input logic [7:0] exp, input string req);
      item_t it;
      it.is_irq = is_irq;
      it.exp    = exp;
      it.req    = req;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic pulse(input logic [5:0] m);
      evt_i = m;
      cyc();
      evt_i = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
      rd_en = 1'b1; addr = a;
      cyc();
      expect_item(1'b0, exp, req);
      rd_en = 1'b0;
      cyc();
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      expect_item(1'b1, 8'h00, "R1 irq after reset");
      rd(2'd0, 8'h00, "R1 status");
      rd(2'd1, 8'h00, "R1 control");
      rd(2'd3, 8'h00, "R1 ext enable");

      // R2 polling without enable, R5 clear on read
      pulse(6'b000001);
      expect_item(1'b1, 8'h00, "R2 disabled flag no irq");
      rd(2'd0, 8'h40, "R2 periodic flag polled");
      rd(2'd0, 8'h00, "R5 cleared after read");

      // R4 enabling a flag that is already set
      pulse(6'b000010);
      wr(2'd1, 8'h20);
      expect_item(1'b1, 8'h01, "R4 irq after enable");
      rd(2'd0, 8'hA0, "R3 summary and alarm");
      expect_item(1'b1, 8'h00, "R3 irq drops after clear");

      // R8 write to status ignored, low bits zero
      pulse(6'b000100);
      wr(2'd0, 8'hFF);
      rd(2'd0, 8'h10, "R8 status write ignored");

      // R9 hold bit drops update-ended enable
      wr(2'd1, 8'h10);
      rd(2'd1, 8'h10, "R9 update enable stored");
      wr(2'd1, 8'h90);
      rd(2'd1, 8'h80, "R9 hold clears update enable");
      wr(2'd1, 8'h70);
      rd(2'd1, 8'h70, "R9 all primary enables");

      // R6 frozen read, events during and at end of read
      pulse(6'b000001);
      rd_en = 1'b1; addr = 2'd0;
      cyc();
      expect_item(1'b0, 8'hC0, "R6 first read data");
      evt_i = 6'b000010;
      cyc();
      evt_i = '0;
      expect_item(1'b0, 8'hC0, "R6 read data frozen");
      rd_en = 1'b0; evt_i = 6'b000100;
      cyc();
      evt_i = '0;
      expect_item(1'b1, 8'h01, "R6 parked events raise irq");
      rd(2'd0, 8'hB0, "R6 parked and end-cycle events posted");
      expect_item(1'b1, 8'h00, "R6 irq clear");

      // R7 extended flags: sticky over reads, write-one clear
      pulse(6'b001000);
      rd(2'd2, 8'h01, "R7 wake flag");
      rd(2'd2, 8'h01, "R7 not cleared by read");
      expect_item(1'b1, 8'h00, "R2 ext disabled no irq");
      wr(2'd3, 8'h01);
      expect_item(1'b1, 8'h01, "R4 ext enable preset flag");
      wr(2'd2, 8'h01);
      expect_item(1'b1, 8'h00, "R7 write clear drops irq");
      rd(2'd2, 8'h00, "R7 wake cleared");
      evt_i = 6'b010000; wr_en = 1'b1; addr = 2'd2; wdata = 8'h02;
      cyc();
      evt_i = '0; wr_en = 1'b0;
      rd(2'd2, 8'h02, "R7 event beats clear");

      // R10 summary held until every enabled flag clears
      wr(2'd3, 8'h07);
      pulse(6'b100000);
      expect_item(1'b1, 8'h01, "R10 irq set");
      wr(2'd2, 8'h02);
      expect_item(1'b1, 8'h01, "R10 partial clear keeps irq");
      rd(2'd0, 8'h80, "R10 summary with no primary flag");
      wr(2'd2, 8'h04);
      expect_item(1'b1, 8'h00, "R10 all cleared");
      rd(2'd0, 8'h00, "R3 summary zero");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule